// File: doc/BRIEF.md
# Five-Channel PWM Bank with Request/Acknowledge Stop

The block holds a row of identical pulse-width channels sharing one word-wide register port. Every channel owns a private window of registers. Each channel picks one of three timing strobes as its count source. It thins that strobe with a divider and runs a counter from zero to its period. Its output is active while the counter sits inside a window bounded by two thresholds. An inversion bit sets the polarity, and a software override can force the pin to a fixed level.

Software stops a channel by raising a stop request and then polling a read-only stopped flag. In abrupt mode the channel halts on the next clock. In graceful mode it finishes the period in progress first. A stopped channel holds its counter at zero and drives its inactive level. Each channel can also count completed periods and raise a sticky interrupt bit after a programmed number of them. The sticky bits sit in one shared status register, and software clears them by writing ones.

Top module: `pwm_bank`

## Requirements
- R1: After reset every channel reports stop request and stopped flag set (its control word reads 0xC0), every output is 0 and irq is 0.
- R2: Channel n's registers sit at n*0x20: control +0x00, divider +0x04, low threshold +0x08, high threshold +0x0C, period +0x10, interrupt +0x14. The 16-bit fields read back truncated to 16 bits, writes to one channel leave the others unchanged, and control bit 7 reflects only the stopped state and ignores writes.
- R3: While running, the counter advances on every (D+1)-th selected source strobe, where D is the divider, and returns to 0 after it reaches period-1. A counter that was just released reads 0 for the first cycle after release.
- R4: The output is active while low threshold <= counter < high threshold, and control bit 2 inverts it.
- R5: Control bits 1:0 select the count source: 0 tick_xtal, 1 tick_bus, 2 tick_slow, 3 none (counter frozen).
- R6: With control bit 3 = 0 (abrupt), setting control bit 6 stops the channel on the next clock. The stopped flag then reads 1, and the output rests at the bit-2 level. Clearing bit 6 clears the flag one clock later, and counting restarts from 0.
- R7: With control bit 3 = 1 (graceful), a stop request takes effect only on the strobe that wraps the counter, and the output keeps running until then.
- R8: Control bit 5 forces the output to control bit 4, without inversion and whether the channel is running or stopped.
- R9: The interrupt register holds a period count N in bits 15:0 and an enable in bit 16. With the enable set, every N-th counter wrap sets status bit n of the shared register at NCH*0x20 (0xA0). irq is the OR of the status bits.
- R10: Writing the shared register with bit 8+n set clears status bit n. A wrap that sets the bit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_xtal | input | 1 | Count strobe, source 0 |
| tick_bus | input | 1 | Count strobe, source 1 |
| tick_slow | input | 1 | Count strobe, source 2 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (8) | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_out | output | NCH (5) | Channel outputs |
| irq | output | 1 | OR of sticky interrupt status bits |

## Verification
A wrong counter value shows on the channel's output during the same cycle. The bench predicts the counter as ((i-1)/(D+1)) mod P, where i counts edges after release, and compares the output on every cycle of two full periods. A stopped flag in the wrong state shows up as a wrong control readback, or as an output away from its rest level, one clock after the request or the release. A graceful stop that fires early flattens the output two cycles too soon. The wrap counter is checked by the exact edge at which irq rises, and the clear logic by irq falling on the edge that takes the write.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   localparam int unsigned WIN_SHIFT = 5;

   typedef enum logic [2:0] {
      RS_CTRL = 3'd0,
      RS_DIV  = 3'd1,
      RS_LO   = 3'd2,
      RS_HI   = 3'd3,
      RS_PER  = 3'd4,
      RS_INT  = 3'd5
   } regsel_e;

   typedef enum logic [1:0] {
      SRC_XTAL = 2'd0,
      SRC_BUS  = 2'd1,
      SRC_SLOW = 2'd2,
      SRC_NONE = 2'd3
   } clksrc_e;

   localparam int unsigned B_INV   = 2;
   localparam int unsigned B_GRACE = 3;
   localparam int unsigned B_FVAL  = 4;
   localparam int unsigned B_FEN   = 5;
   localparam int unsigned B_REQ   = 6;
   localparam int unsigned B_INTEN = 16;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int unsigned CW = 16,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          src_tick,
   input  logic [CW-1:0] div,
   output logic          tick
);
   generate
      if (HAS_DIV) begin : g_div
         logic [CW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre <= '0;
            else if (!en)          pre <= '0;
            else if (src_tick)     pre <= (pre >= div) ? '0 : pre + 1'b1;
         end
         assign tick = en && src_tick && (pre >= div);
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^{div, clk, rst_n};
         assign tick = en && src_tick;
      end
   endgenerate
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_bank_pkg::*;
#(
   parameter int unsigned CW = 16,
   parameter bit          HAS_DIV = 1'b1,
   localparam int unsigned DW = CW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [2:0]    rsel,
   input  logic [DW-1:0] wdata,
   input  logic [2:0]    src_vec,
   output logic [31:0]   rdata,
   output logic          out,
   output logic          period_hit,
   output logic          st_stopped,
   output logic          st_req,
   output logic          st_grace,
   output logic          st_inv,
   output logic          st_fen,
   output logic          st_fval
);
   logic [1:0]    src_sel;
   logic          inv, grace, fval, fen, req;
   logic [CW-1:0] div_r, lo_r, hi_r, per_r, nint_r;
   logic          int_en;
   logic          stopped;
   logic [CW-1:0] cnt, wraps;
   logic          src_tick, tick, wrap, stop_now, nth;
   logic          unused_w;

   assign unused_w = wdata[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_sel <= '0; inv <= 1'b0; grace <= 1'b0; fval <= 1'b0;
         fen <= 1'b0; req <= 1'b1;
         div_r <= '0; lo_r <= '0; hi_r <= '0; per_r <= '0;
         nint_r <= '0; int_en <= 1'b0;
      end else if (we) begin
         case (regsel_e'(rsel))
            RS_CTRL: begin
               src_sel <= wdata[1:0];
               inv     <= wdata[B_INV];
               grace   <= wdata[B_GRACE];
               fval    <= wdata[B_FVAL];
               fen     <= wdata[B_FEN];
               req     <= wdata[B_REQ];
            end
            RS_DIV:  div_r <= wdata[CW-1:0];
            RS_LO:   lo_r  <= wdata[CW-1:0];
            RS_HI:   hi_r  <= wdata[CW-1:0];
            RS_PER:  per_r <= wdata[CW-1:0];
            RS_INT: begin
               nint_r <= wdata[CW-1:0];
               int_en <= wdata[B_INTEN];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (clksrc_e'(src_sel))
         SRC_XTAL: src_tick = src_vec[0];
         SRC_BUS:  src_tick = src_vec[1];
         SRC_SLOW: src_tick = src_vec[2];
         default:  src_tick = 1'b0;
      endcase
   end

   pwm_prescale #(.CW(CW), .HAS_DIV(HAS_DIV)) i_pre (
      .clk(clk), .rst_n(rst_n), .en(!stopped), .src_tick(src_tick),
      .div(div_r), .tick(tick)
   );

   assign wrap     = ({1'b0, cnt} + 1'b1) >= {1'b0, per_r};
   assign stop_now = req && !stopped && (!grace || (tick && wrap));
   assign nth      = (nint_r != '0) && (({1'b0, wraps} + 1'b1) == {1'b0, nint_r});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stopped <= 1'b1;
         cnt     <= '0;
         wraps   <= '0;
      end else begin
         if (stopped && !req)  stopped <= 1'b0;
         else if (stop_now)    stopped <= 1'b1;

         if (stopped || stop_now) begin
            cnt   <= '0;
            wraps <= '0;
         end else if (tick) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
            if (wrap) wraps <= nth ? '0 : wraps + 1'b1;
         end
      end
   end

   assign period_hit = int_en && !stopped && !stop_now && tick && wrap && nth;

   logic active;
   assign active = !stopped && (cnt >= lo_r) && (cnt < hi_r);
   assign out    = fen ? fval : (active ^ inv);

   always_comb begin
      case (regsel_e'(rsel))
         RS_CTRL: rdata = {24'd0, stopped, req, fen, fval, grace, inv, src_sel};
         RS_DIV:  rdata = 32'(div_r);
         RS_LO:   rdata = 32'(lo_r);
         RS_HI:   rdata = 32'(hi_r);
         RS_PER:  rdata = 32'(per_r);
         RS_INT:  rdata = 32'(nint_r) | (32'(int_en) << B_INTEN);
         default: rdata = 32'd0;
      endcase
   end

   assign st_stopped = stopped;
   assign st_req     = req;
   assign st_grace   = grace;
   assign st_inv     = inv;
   assign st_fen     = fen;
   assign st_fval    = fval;
endmodule

// File: rtl/pwm_irqstat.sv
module pwm_irqstat #(
   parameter int unsigned NCH = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set,
   input  logic           clr_we,
   input  logic [NCH-1:0] clr_mask,
   output logic [NCH-1:0] status,
   output logic           irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= (status & ~(clr_we ? clr_mask : '0)) | set;
   end
   assign irq = |status;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH = 5,
   parameter int unsigned CW  = 16,
   parameter int unsigned AW  = 8,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick_xtal,
   input  logic           tick_bus,
   input  logic           tick_slow,
   input  logic           reg_we,
   input  logic [AW-1:0]  reg_addr,
   input  logic [31:0]    reg_wdata,
   output logic [31:0]    reg_rdata,
   output logic [NCH-1:0] pwm_out,
   output logic           irq
);
   localparam int unsigned IW = AW - WIN_SHIFT;
   localparam int unsigned DW = CW + 1;

   generate
      if (NCH < 1 || NCH > 8)      begin : g_bad_nch $error("NCH must be 1..8"); end
      if (CW < 2 || CW > 16)       begin : g_bad_cw  $error("CW must be 2..16"); end
      if (AW <= WIN_SHIFT || NCH >= (1 << (AW - WIN_SHIFT)))
                                   begin : g_bad_aw  $error("AW too small for NCH windows"); end
   endgenerate

   logic [IW-1:0]  win;
   logic [2:0]     rsel;
   logic [31:0]    ch_rd [NCH];
   logic [NCH-1:0] hit_v, stp_v, req_v, grc_v, inv_v, fen_v, fvl_v;
   logic [NCH-1:0] status;
   logic           clr_we;
   logic           unused_hi;

   assign win       = reg_addr[AW-1:WIN_SHIFT];
   assign rsel      = reg_addr[4:2];
   assign unused_hi = ^{reg_wdata[31:DW], reg_addr[1:0]};
   assign clr_we    = reg_we && (win == IW'(NCH)) && (rsel == 3'd0);

   genvar g;
   generate
      for (g = 0; g < NCH; g++) begin : g_ch
         pwm_chan #(.CW(CW), .HAS_DIV(HAS_DIV)) i_chan (
            .clk(clk), .rst_n(rst_n),
            .we(reg_we && (win == IW'(g))),
            .rsel(rsel), .wdata(reg_wdata[DW-1:0]),
            .src_vec({tick_slow, tick_bus, tick_xtal}),
            .rdata(ch_rd[g]), .out(pwm_out[g]), .period_hit(hit_v[g]),
            .st_stopped(stp_v[g]), .st_req(req_v[g]), .st_grace(grc_v[g]),
            .st_inv(inv_v[g]), .st_fen(fen_v[g]), .st_fval(fvl_v[g])
         );
      end
   endgenerate

   pwm_irqstat #(.NCH(NCH)) i_irq (
      .clk(clk), .rst_n(rst_n), .set(hit_v), .clr_we(clr_we),
      .clr_mask(reg_wdata[8 +: NCH]), .status(status), .irq(irq)
   );

   always_comb begin
      reg_rdata = 32'd0;
      for (int i = 0; i < NCH; i++)
         if (win == IW'(i)) reg_rdata = ch_rd[i];
      if (win == IW'(NCH) && rsel == 3'd0) reg_rdata = 32'(status);
   end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int unsigned NCH = 5
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] pwm_out,
   input logic [NCH-1:0] stp_v,
   input logic [NCH-1:0] req_v,
   input logic [NCH-1:0] grc_v,
   input logic [NCH-1:0] inv_v,
   input logic [NCH-1:0] fen_v,
   input logic [NCH-1:0] fvl_v,
   input logic [NCH-1:0] hit_v,
   input logic [NCH-1:0] status,
   input logic           clr_we,
   input logic [NCH-1:0] clr_mask,
   input logic           irq
);
   genvar g;
   generate
      for (g = 0; g < NCH; g++) begin : g_a
         p_abrupt_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            req_v[g] && !grc_v[g] && !stp_v[g] |=> stp_v[g]);
         p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !req_v[g] && stp_v[g] |=> !stp_v[g]);
         p_hold_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            req_v[g] && stp_v[g] |=> stp_v[g]);
         p_park_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stp_v[g]) && !fen_v[g] |-> pwm_out[g] == inv_v[g]);
         p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fen_v[g] |-> pwm_out[g] == fvl_v[g]);
         p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
            clr_we && clr_mask[g] && !hit_v[g] |=> !status[g]);
         p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            hit_v[g] |=> status[g]);
      end
   endgenerate

   p_irq_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (status != '0));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) i_pwm_bank_chk (
   .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .stp_v(stp_v),
   .req_v(req_v), .grc_v(grc_v), .inv_v(inv_v), .fen_v(fen_v),
   .fvl_v(fvl_v), .hit_v(hit_v), .status(status), .clr_we(clr_we),
   .clr_mask(reg_wdata[8 +: NCH]), .irq(irq)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;
   localparam int NCH = 5;
   logic clk = 1'b0, rst_n = 1'b0;
   logic tick_xtal = 1'b1, tick_bus = 1'b1, tick_slow = 1'b0;
   logic reg_we = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [NCH-1:0] pwm_out;
   logic irq;
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pwm_bank i_pwm_bank (
      .clk(clk), .rst_n(rst_n), .tick_xtal(tick_xtal), .tick_bus(tick_bus),
      .tick_slow(tick_slow), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge; the write lands on the next posedge, returns at the following negedge
   task automatic wr(logic [7:0] a, logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   function automatic logic exp_out(int c, int lo, int hi, logic inv);
      return ((c >= lo) && (c < hi)) ^ inv;
   endfunction

   function automatic logic [7:0] ra(int ch, int off);
      return 8'(ch * 32 + off);
   endfunction

   initial begin
      #(20ns * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic ok;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int c = 0; c < NCH; c++) begin
         rd(ra(c, 0), d); chk("R1 ctrl", d, 32'hC0);
      end
      chk("R1 out", 32'(pwm_out), 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);

      // R2 map, truncation, isolation, read-only flag
      wr(ra(3, 12), 32'hABCD_1234);
      rd(ra(3, 12), d); chk("R2 trunc", d, 32'h1234);
      wr(ra(1, 16), 32'd7);
      rd(ra(1, 16), d); chk("R2 per ch1", d, 32'd7);
      rd(ra(2, 16), d); chk("R2 per ch2 untouched", d, 32'd0);
      wr(ra(3, 0), 32'h0000_0000);
      rd(ra(3, 0), d); chk("R2 flag ignores write", d, 32'h80);
      @(negedge clk);
      rd(ra(3, 0), d); chk("R6 release one clock later", d, 32'h00);
      wr(ra(3, 0), 32'h40);

      // R3 R4 R5: random trials on sources 0/1
      for (int t = 0; t < 12; t++) begin
         int ch = int'($urandom % NCH);
         int p  = 2 + int'($urandom % 19);
         int lo = int'($urandom % (p + 1));
         int hi = int'($urandom % (p + 3));
         int dv = int'($urandom % 3);
         logic inv = 1'($urandom % 2);
         logic [1:0] src = 2'($urandom % 2);
         logic [31:0] cw = {29'd0, inv, src};
         wr(ra(ch, 0), cw | 32'h40);
         wr(ra(ch, 4), 32'(dv));
         wr(ra(ch, 8), 32'(lo));
         wr(ra(ch, 12), 32'(hi));
         wr(ra(ch, 16), 32'(p));
         wr(ra(ch, 0), cw);
         ok = 1'b1;
         for (int i = 1; i <= 2 * p * (dv + 1) + 2; i++) begin
            @(negedge clk);
            if (pwm_out[ch] !== exp_out(((i - 1) / (dv + 1)) % p, lo, hi, inv)) begin
               if (ok) chk("R3 R4 waveform", 32'(pwm_out[ch]),
                           32'(exp_out(((i - 1) / (dv + 1)) % p, lo, hi, inv)));
               ok = 1'b0;
            end
         end
         if (ok) chk("R3 R4 waveform", 32'h1, 32'h1);
         wr(ra(ch, 0), 32'h40);
      end

      // R5 slow source and no source on ch0
      wr(ra(0, 4), 32'd0); wr(ra(0, 8), 32'd0); wr(ra(0, 12), 32'd1); wr(ra(0, 16), 32'd4);
      wr(ra(0, 0), 32'h02);
      ok = 1'b1;
      repeat (6) begin @(negedge clk); if (pwm_out[0] !== 1'b1) ok = 1'b0; end
      chk("R5 slow source idle holds count 0", 32'(ok), 32'h1);
      tick_slow = 1'b1; @(negedge clk); tick_slow = 1'b0;
      chk("R5 slow strobe advances", 32'(pwm_out[0]), 32'h0);
      wr(ra(0, 0), 32'h03);
      ok = 1'b1;
      repeat (8) begin @(negedge clk); if (pwm_out[0] !== 1'b0) ok = 1'b0; end
      chk("R5 source 3 frozen", 32'(ok), 32'h1);

      // R6 abrupt stop with inversion
      wr(ra(0, 12), 32'd2); wr(ra(0, 16), 32'd8);
      wr(ra(0, 0), 32'h05);
      repeat (3) @(negedge clk);
      wr(ra(0, 0), 32'h45);
      rd(ra(0, 0), d); chk("R6 not yet stopped", d & 32'h80, 32'h0);
      @(negedge clk);
      rd(ra(0, 0), d); chk("R6 stopped next clock", d, 32'hC5);
      ok = 1'b1;
      repeat (5) begin @(negedge clk); if (pwm_out[0] !== 1'b1) ok = 1'b0; end
      chk("R6 rest level inverted", 32'(ok), 32'h1);

      // R7 graceful stop on ch1
      wr(ra(1, 4), 32'd0); wr(ra(1, 8), 32'd2); wr(ra(1, 12), 32'd6); wr(ra(1, 16), 32'd6);
      wr(ra(1, 0), 32'h01);
      repeat (3) @(negedge clk);
      wr(ra(1, 0), 32'h49);
      rd(ra(1, 0), d); chk("R7 running after request", d & 32'h80, 32'h0);
      chk("R7 out cnt3", 32'(pwm_out[1]), 32'h1);
      @(negedge clk);
      rd(ra(1, 0), d); chk("R7 still running cnt4", d & 32'h80, 32'h0);
      chk("R7 out cnt4", 32'(pwm_out[1]), 32'h1);
      @(negedge clk);
      chk("R7 out cnt5", 32'(pwm_out[1]), 32'h1);
      @(negedge clk);
      rd(ra(1, 0), d); chk("R7 stopped at wrap", d & 32'h80, 32'h80);
      chk("R7 parked", 32'(pwm_out[1]), 32'h0);

      // R8 override
      wr(ra(1, 0), 32'h70);
      chk("R8 force 1 while stopped", 32'(pwm_out[1]), 32'h1);
      wr(ra(1, 0), 32'h64);
      chk("R8 force 0 not inverted", 32'(pwm_out[1]), 32'h0);
      wr(ra(1, 0), 32'h40);

      // R9 R10 interrupt on ch2, period 4, every 3 wraps
      wr(ra(2, 4), 32'd0); wr(ra(2, 8), 32'd0); wr(ra(2, 12), 32'd2); wr(ra(2, 16), 32'd4);
      wr(ra(2, 20), 32'h0001_0003);
      wr(ra(2, 0), 32'h01);
      repeat (12) @(negedge clk);
      chk("R9 irq before third wrap", 32'(irq), 32'h0);
      @(negedge clk);
      chk("R9 irq at third wrap", 32'(irq), 32'h1);
      rd(8'hA0, d); chk("R9 status bit", d, 32'h04);
      wr(8'hA0, 32'h0000_0400);
      chk("R10 clear", 32'(irq), 32'h0);
      rd(8'hA0, d); chk("R10 status cleared", d, 32'h0);
      repeat (10) @(negedge clk);
      chk("R9 irq before sixth wrap", 32'(irq), 32'h0);
      @(negedge clk);
      chk("R9 irq at sixth wrap", 32'(irq), 32'h1);
      wr(8'hA0, 32'h0000_0400);
      repeat (10) @(negedge clk);
      wr(8'hA0, 32'h0000_0400);
      chk("R10 set wins over clear", 32'(irq), 32'h1);
      wr(ra(2, 0), 32'h40);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule